// File: doc/BRIEF.md
# External Interrupt Input Controller

This block takes up to four asynchronous interrupt pins from outside the chip and turns each one into its own request line toward a parent interrupt controller. Every pin is brought into the clock domain through a two-stage synchroniser. It is then judged against a per-pin trigger type: rising edge, falling edge, any edge, active-high level or active-low level. The result is a status bit that software can read, and a masked, registered request output.

Software sees one 32-bit control word. The word is split into six fields of `FIELD_W` bits each, and each pin owns bit `n` of every field. Software uses the word to pick the trigger type, to enable or mask each request, and to acknowledge latched edge events with write-one-to-clear. The status field is read-only. The acknowledge field is write-only and always reads as zero.

Top module: `ext_irq_ctrl`

## Requirements
- R1: During a cycle with `rst_n` low, every configuration register, every status bit and every request output is cleared. After reset, `rd_data` reads 0 and `irq_o` is 0, so every pin starts masked and set to rising edge.
- R2: The field at index k occupies `rd_data`/`wr_data` bits `k*FIELD_W + n` for pin n. The field indices are: 0 sense, 1 status, 2 acknowledge, 3 enable, 4 any-edge, 5 level. A pin whose level bit, any-edge bit and sense bit are all 0 detects rising edges. A 0-to-1 pin change shows in the status bit after the third rising clock edge that follows the change.
- R3: Level=0, any-edge=0, sense=1 selects falling edge. A 1-to-0 pin change sets the status bit, and a 0-to-1 change does not.
- R4: Level=0 with any-edge=1 sets the status bit on either pin transition, whatever the sense bit holds.
- R5: In the edge modes the status bit stays set until a write carries 1 in that pin's acknowledge bit. A write with 0 in that bit leaves the status bit unchanged.
- R6: If a qualifying edge and an acknowledge for the same pin take effect on the same clock edge, the status bit remains set.
- R7: Level=1 with sense=1 selects active-high level. The status bit equals the synchronised pin value, and an acknowledge has no effect while the pin is high.
- R8: Level=1 with sense=0 selects active-low level. The status bit is 1 exactly while the synchronised pin is 0.
- R9: `irq_o[n]` is a register loaded with status[n] AND enable[n], so it follows a status or enable change one clock edge later. An enable bit of 0 holds the request low.
- R10: Writes to the status field are ignored, and the acknowledge field always reads 0.
- R11: The sense, enable, any-edge and level fields read back the value last written. Bits at and above `6*FIELD_W`, and bits at positions n ≥ `NUM_IN` inside a field, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | NUM_IN | Asynchronous external interrupt pins |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | DATA_W | Write data for the control word |
| rd_data | output | DATA_W | Current value of the control word |
| irq_o | output | NUM_IN | Per-pin request lines to the parent controller |

## Verification
The assertions check four things on every cycle:
- the reset clearing;
- the one-edge relation between status AND enable and the request outputs;
- that an edge-mode status bit cannot drop without an acknowledge;
- that written configuration reads back.

They cannot see the synchronised pin samples, so trigger detection itself is left to the bench. The bench sweeps all five trigger types across every pin. At each step it predicts, from the pin history, which status bit should be set and when. It also covers the acknowledge-while-active case, the acknowledge colliding with a new edge, masking, and writes into the read-only fields.

// File: rtl/ext_irq_pkg.sv
// Shared field indices and per-pin trigger configuration type.
// Assumes fields are laid out from bit 0 upward in the index order below.
package ext_irq_pkg;
    localparam int FLD_SENSE = 0;
    localparam int FLD_STAT  = 1;
    localparam int FLD_ACK   = 2;
    localparam int FLD_EN    = 3;
    localparam int FLD_ANY   = 4;
    localparam int FLD_LVL   = 5;
    localparam int NUM_FLD   = 6;

    typedef struct packed {
        logic sense;   // edge: 0 rising / 1 falling; level: active value
        logic any;     // any-edge select
        logic lvl;     // level-triggered select
    } trig_cfg_t;
endpackage

// File: rtl/ext_irq_sync.sv
// Two-flop synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherency is provided.
module ext_irq_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the pins through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/ext_irq_line.sv
// Per-pin trigger detection and status bit.
// Assumes smp_i is already synchronous. Edge modes latch a sticky status,
// and a new edge wins over a simultaneous acknowledge. Level modes track
// the qualified level and ignore acknowledges.
module ext_irq_line
    import ext_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      smp_i,
    input  trig_cfg_t cfg_i,
    input  logic      ack_i,
    output logic      stat_o
);
    logic prev_q;
    logic stat_q;
    logic rise;
    logic fall;
    logic evt;

    // Classify the transition between the previous and current samples.
    always_comb begin
        rise = smp_i & ~prev_q;
        fall = ~smp_i & prev_q;
        if (cfg_i.any)
            evt = rise | fall;
        else if (cfg_i.sense)
            evt = fall;
        else
            evt = rise;
    end

    // Hold the previous sample and update status for the selected mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            prev_q <= smp_i;
            if (cfg_i.lvl)
                stat_q <= (smp_i == cfg_i.sense);
            else
                stat_q <= evt | (stat_q & ~ack_i);
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/ext_irq_regs.sv
// Control word storage and read-back mux.
// Assumes one word. Status is supplied from the line logic. The acknowledge
// field is a one-cycle pulse taken from the write data and is never stored.
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [NUM_IN-1:0]       stat_i,
    output trig_cfg_t [NUM_IN-1:0]  cfg_o,
    output logic [NUM_IN-1:0]       en_o,
    output logic [NUM_IN-1:0]       ack_o,
    output logic [DATA_W-1:0]       rd_data
);
    localparam int OFS_SENSE = FLD_SENSE * FIELD_W;
    localparam int OFS_STAT  = FLD_STAT  * FIELD_W;
    localparam int OFS_ACK   = FLD_ACK   * FIELD_W;
    localparam int OFS_EN    = FLD_EN    * FIELD_W;
    localparam int OFS_ANY   = FLD_ANY   * FIELD_W;
    localparam int OFS_LVL   = FLD_LVL   * FIELD_W;

    logic [NUM_IN-1:0] sense_q;
    logic [NUM_IN-1:0] any_q;
    logic [NUM_IN-1:0] lvl_q;
    logic [NUM_IN-1:0] en_q;
    logic              unused_wr;

    // Capture the writable configuration fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            any_q   <= '0;
            lvl_q   <= '0;
            en_q    <= '0;
        end else if (wr_en) begin
            sense_q <= wr_data[OFS_SENSE +: NUM_IN];
            any_q   <= wr_data[OFS_ANY   +: NUM_IN];
            lvl_q   <= wr_data[OFS_LVL   +: NUM_IN];
            en_q    <= wr_data[OFS_EN    +: NUM_IN];
        end
    end

    // Acknowledge pulse exists only in the cycle of the write.
    assign ack_o     = wr_en ? wr_data[OFS_ACK +: NUM_IN] : '0;
    assign en_o      = en_q;
    assign unused_wr = ^wr_data;

    for (genvar n = 0; n < NUM_IN; n++) begin : g_cfg
        assign cfg_o[n].sense = sense_q[n];
        assign cfg_o[n].any   = any_q[n];
        assign cfg_o[n].lvl   = lvl_q[n];
    end

    // Assemble the read-back word; the acknowledge field stays zero.
    always_comb begin
        rd_data                         = '0;
        rd_data[OFS_SENSE +: NUM_IN]    = sense_q;
        rd_data[OFS_STAT  +: NUM_IN]    = stat_i;
        rd_data[OFS_EN    +: NUM_IN]    = en_q;
        rd_data[OFS_ANY   +: NUM_IN]    = any_q;
        rd_data[OFS_LVL   +: NUM_IN]    = lvl_q;
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
// External interrupt input controller top.
// Assumes NUM_IN <= FIELD_W and all six fields fit in DATA_W.
// Pin to status latency is three clock edges; status to request is one more.
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] pin_i,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_IN-1:0] irq_o
);
    localparam int USED_W = NUM_FLD * FIELD_W;

    if (NUM_IN > FIELD_W || USED_W > DATA_W) begin : g_bad_cfg
        initial $error("ext_irq_ctrl: fields do not fit the control word");
    end

    logic [NUM_IN-1:0]      smp;
    logic [NUM_IN-1:0]      stat;
    logic [NUM_IN-1:0]      en;
    logic [NUM_IN-1:0]      ack;
    trig_cfg_t [NUM_IN-1:0] cfg;
    logic [NUM_IN-1:0]      irq_q;

    ext_irq_sync #(.W(NUM_IN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (smp)
    );

    ext_irq_regs #(
        .NUM_IN  (NUM_IN),
        .FIELD_W (FIELD_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .stat_i  (stat),
        .cfg_o   (cfg),
        .en_o    (en),
        .ack_o   (ack),
        .rd_data (rd_data)
    );

    for (genvar n = 0; n < NUM_IN; n++) begin : g_line
        ext_irq_line u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp_i  (smp[n]),
            .cfg_i  (cfg[n]),
            .ack_i  (ack[n]),
            .stat_o (stat[n])
        );
    end

    // Register the enabled status as the request toward the parent.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= '0;
        else
            irq_q <= stat & en;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/ext_irq_chk.sv
// Port-level checker for ext_irq_ctrl, attached with bind.
// Assumes the field layout from ext_irq_pkg.
module ext_irq_chk
    import ext_irq_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [NUM_IN-1:0] irq_o
);
    logic [NUM_IN-1:0] c_stat;
    logic [NUM_IN-1:0] c_en;
    logic [NUM_IN-1:0] c_lvl;
    logic [NUM_IN-1:0] c_sense;
    logic [NUM_IN-1:0] w_ack;
    logic [NUM_IN-1:0] w_sense;
    logic              unused_chk;

    assign c_stat     = rd_data[FLD_STAT  * FIELD_W +: NUM_IN];
    assign c_en       = rd_data[FLD_EN    * FIELD_W +: NUM_IN];
    assign c_lvl      = rd_data[FLD_LVL   * FIELD_W +: NUM_IN];
    assign c_sense    = rd_data[FLD_SENSE * FIELD_W +: NUM_IN];
    assign w_ack      = wr_data[FLD_ACK   * FIELD_W +: NUM_IN];
    assign w_sense    = wr_data[FLD_SENSE * FIELD_W +: NUM_IN];
    assign unused_chk = ^{rd_data, wr_data};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && irq_o == '0)); // R1

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> irq_o == $past(c_stat & c_en)); // R9

    AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |-> c_sense == $past(w_sense)); // R11

    for (genvar n = 0; n < NUM_IN; n++) begin : g_ln
        AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(c_stat[n]) && !$past(c_lvl[n])
             && !($past(wr_en) && $past(w_ack[n]))) |-> c_stat[n]); // R5
    end
endmodule

bind ext_irq_ctrl ext_irq_chk #(
    .NUM_IN  (NUM_IN),
    .FIELD_W (FIELD_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq_o   (irq_o)
);

// File: tb/test_ext_irq_ctrl.sv
// Self-checking bench: sweeps every trigger type on every pin, then
// exercises acknowledge collisions, masking and read-only fields.
module test_ext_irq_ctrl;
    localparam int NI = 4;
    localparam int FW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [NI-1:0] pins = '0;
    logic [DW-1:0] rd_data;
    logic [NI-1:0] irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    ext_irq_ctrl #(.NUM_IN(NI), .FIELD_W(FW), .DATA_W(DW)) i_ext_irq_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pins),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_o   (irq)
    );

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] fld(input int k, input logic [NI-1:0] v);
        return DW'(v) << (k * FW);
    endfunction

    function automatic logic [NI-1:0] stat_of(input logic [DW-1:0] w);
        return w[FW +: NI];
    endfunction

    // mode: 0 rising, 1 falling, 2 any edge, 3 level high, 4 level low
    function automatic logic [DW-1:0] cfg_word(input int mode, input int ln);
        logic [NI-1:0] b;
        b = NI'(1) << ln;
        case (mode)
            1:       return fld(0, b);
            2:       return fld(4, b);
            3:       return fld(5, b) | fld(0, b);
            4:       return fld(5, b);
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [DW-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_pin(input int ln, input logic v);
        @(negedge clk);
        pins[ln] = v;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [DW-1:0] cw;
        logic [NI-1:0] b;
        logic [NI-1:0] ex;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset word", rd_data, '0);
        chk("R1 reset irq", DW'(irq), '0);

        // Sweep every trigger type on every pin (R2 R3 R4 R5 R7 R8 R9).
        for (int m = 0; m < 5; m++) begin
            for (int ln = 0; ln < NI; ln++) begin
                b  = NI'(1) << ln;
                cw = cfg_word(m, ln) | fld(3, '1);
                @(negedge clk);
                pins = '0;
                wr(cw);
                waitc(3);
                wr(cw | fld(2, '1));
                ex = (m == 4) ? b : '0;
                chk("R8 idle status", DW'(stat_of(rd_data)), DW'(ex));

                set_pin(ln, 1'b1);
                waitc(3);
                ex = (m == 0 || m == 2 || m == 3) ? b : '0;
                chk("R2 R3 R4 R7 R8 status after rise", DW'(stat_of(rd_data)), DW'(ex));
                waitc(1);
                chk("R9 irq after rise", DW'(irq), DW'(ex));

                wr(cw | fld(2, '1));
                ex = (m == 3) ? b : '0;
                chk("R5 R7 status after ack", DW'(stat_of(rd_data)), DW'(ex));

                set_pin(ln, 1'b0);
                waitc(3);
                ex = (m == 1 || m == 2 || m == 4) ? b : '0;
                chk("R3 R4 R7 R8 status after fall", DW'(stat_of(rd_data)), DW'(ex));
                waitc(1);
                chk("R9 irq after fall", DW'(irq), DW'(ex));
            end
        end

        // Edge/acknowledge collision and write-zero acknowledge (R5 R6).
        wr(fld(3, 4'h1));
        waitc(3);
        wr(fld(3, 4'h1) | fld(2, '1));
        set_pin(0, 1'b1);
        waitc(3);
        chk("R2 pin0 rising latched", DW'(stat_of(rd_data)), 32'h1);
        wr(fld(3, 4'h1));
        chk("R5 ack bit zero keeps status", DW'(stat_of(rd_data)), 32'h1);
        set_pin(0, 1'b0);
        waitc(3);
        chk("R2 falling ignored in rising mode", DW'(stat_of(rd_data)), 32'h1);
        set_pin(0, 1'b1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = fld(3, 4'h1) | fld(2, 4'h1);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
        chk("R6 edge with ack keeps status", DW'(stat_of(rd_data)), 32'h1);
        wr(fld(3, 4'h1) | fld(2, 4'h1));
        chk("R5 ack clears status", DW'(stat_of(rd_data)), 32'h0);

        // Masking (R9): latch an event, then gate the request.
        set_pin(0, 1'b0);
        waitc(3);
        set_pin(0, 1'b1);
        waitc(3);
        wr(32'h0);
        waitc(1);
        chk("R9 masked request low", DW'(irq), 32'h0);
        wr(fld(3, 4'h1));
        chk("R9 request one edge after enable", DW'(irq), 32'h0);
        waitc(1);
        chk("R9 request follows enable", DW'(irq), 32'h1);
        chk("R9 status kept while masked", DW'(stat_of(rd_data)), 32'h1);

        // Read-only status and write-only acknowledge (R10).
        wr(fld(3, '1) | fld(2, '1));
        set_pin(0, 1'b0);
        waitc(3);
        wr(fld(1, '1) | fld(3, '1));
        chk("R10 status write ignored", DW'(stat_of(rd_data)), 32'h0);
        chk("R10 ack field reads zero", rd_data & fld(2, '1), 32'h0);
        waitc(1);
        chk("R10 no request from status write", DW'(irq), 32'h0);

        // Field layout read-back (R11).
        cw = fld(0, 4'h5) | fld(3, 4'h9) | fld(4, 4'hA) | fld(5, 4'h6);
        wr(cw | 32'hFF00_0000 | fld(2, '1));
        chk("R11 config read-back", rd_data & ~fld(1, '1), cw);

        summary();
    end
endmodule